// File: doc/BRIEF.md
# Power-of-Two Recursive Waveform Averager

This block averages a repetitive 8-bit waveform point by point over successive sweeps. Each record point has its own 16-bit accumulator in an internal single-port RAM, kept in 8.8 fixed point (integer sample bits, then fraction bits). Each accepted sample moves its point's accumulator towards the sample by the difference between them, divided by 2^k. The divide is an arithmetic right shift. The result is a first-order recursive (single-pole) filter per point, with an effective averaging count of 2 to 256.

The shift can quantize in three ways. Truncation drops the shifted-out bits. This produces the flat dead-band plateaus that appear on noisy traces at large k. Rounding adds half of one step before the shift. Dither adds pseudo-random bits below the step before the shift. Switching between the modes shows the artifact and then removes it.

Each sample arrives with its point index and a sweep-start flag. The first sweep after reset, or after any change of k, loads the accumulators directly instead of averaging. The control is a two-state machine:
- ST_IDLE raises `in_ready`, reads the accumulator of an offered sample and moves to ST_WRITE on acceptance.
- ST_WRITE computes the update, writes it back, registers the output and always returns to ST_IDLE.

Top module: `wave_avg_engine`

## Requirements
- R1: During and directly after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the cycle after an acceptance and 1 again in the cycle after that. `out_valid` is 1, with `out_index` equal to the accepted index, in the second cycle after the acceptance and at no other time.
- R3: After reset or a change of the effective k, samples are loaded as sample·256 and output unchanged. Loading continues until the second accepted sample that has `in_sweep_start` set; that sample and all later ones are averaged.
- R4: An averaged update computes delta = sample·256 − acc, then acc_next = acc + floor((delta + bias) / 2^k).
- R5: When `cfg_mode` is 0 (truncate) or 3, bias is 0. With k = 8, an accumulator loaded at 100 and then fed 101 for 150 samples stays at 100 + 1/256, so the output stays 100.
- R6: When `cfg_mode` is 1 (round), bias is 2^(k−1). Under the same stimulus as in R5 the output reaches 101.
- R7: When `cfg_mode` is 2 (dither), bias is the low k bits of a 16-bit LFSR.
  - The LFSR starts at 0xACE1 after reset and shifts left; its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.
  - It advances once per accepted sample in every mode, after that sample has used its bias.
  - The LFSR state is never zero.
- R8: The effective k is `cfg_shift` limited to the range 1..8: a value of 0 acts as 1, and values above 8 act as 8.
- R9: An averaged update never moves the accumulator beyond the sample·256 target, and the result stays within 0..65535. `out_avg` is floor((acc + 128) / 256), saturated at 255.
- R10: Every point keeps its own accumulator, so the result does not depend on the order in which points arrive within a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shift | input | K_W | Requested log2 of the averaging count |
| cfg_mode | input | 2 | Quantizer: 0 truncate, 1 round, 2 dither, 3 truncate |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_sweep_start | input | 1 | Sample is the first one of a sweep |
| in_index | input | IDX_W | Record point index of the sample |
| in_sample | input | SAMPLE_W | Unsigned sample value |
| out_valid | output | 1 | Averaged value present |
| out_index | output | IDX_W | Point index of the averaged value |
| out_avg | output | SAMPLE_W | Rounded averaged value |

## Verification
The bench builds the block with NPOINTS = 16 and keeps the sample width, fraction width and LFSR at their defaults. With only 16 points, every point passes through tens of sweeps, so the recursive state reaches steady values. Points are also revisited in a strided order, which exercises R10. The short record leaves room to drive one point for hundreds of samples at k = 8. That makes the truncation dead band and its removal by rounding and dithering visible at the output. It also lets the bench sweep k through the clamped values 0, 1, 2, 7, 8 and 12.

// File: rtl/wave_avg_pkg.sv
package wave_avg_pkg;

    // Quantizer applied ahead of the divide-by-shift
    typedef enum logic [1:0] {
        QM_TRUNC     = 2'd0,
        QM_ROUND     = 2'd1,
        QM_DITHER    = 2'd2,
        QM_TRUNC_ALT = 2'd3
    } qmode_e;

    // Read-modify-write control
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } avg_state_e;

endpackage

// File: rtl/wave_avg_ram.sv
module wave_avg_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // one port: either a write or a registered read per cycle
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/wave_avg_lfsr.sv
module wave_avg_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] state
);

    logic feedback;

    assign feedback = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (advance) begin
            state <= {state[W-2:0], feedback};
        end
    end

    // R7: a maximal-length register never falls into the all-zero lock-up
    a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/wave_avg_update.sv
module wave_avg_update
    import wave_avg_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int FRAC_W   = 8,
    parameter int K_W      = 4,
    parameter int ACC_W    = SAMPLE_W + FRAC_W
) (
    input  logic [ACC_W-1:0]    acc_old,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [K_W-1:0]      k,
    input  qmode_e              mode,
    input  logic [ACC_W-1:0]    dither,
    input  logic                init,
    output logic [ACC_W-1:0]    acc_new,
    output logic [SAMPLE_W-1:0] avg_out
);

    localparam int             DW      = ACC_W + 3;
    localparam logic [DW-1:0]  ACC_MAX = DW'((64'd1 << ACC_W) - 64'd1);
    localparam logic [DW-1:0]  OUT_MAX = DW'((64'd1 << SAMPLE_W) - 64'd1);
    localparam logic [DW-1:0]  HALF    = DW'(64'd1 << (FRAC_W - 1));

    logic signed [DW-1:0] target;
    logic signed [DW-1:0] acc_ext;
    logic signed [DW-1:0] delta;
    logic signed [DW-1:0] mask;
    logic signed [DW-1:0] bias;
    logic signed [DW-1:0] sum_v;
    logic signed [DW-1:0] step;
    logic signed [DW-1:0] total;
    logic        [DW-1:0] rounded;

    always_comb begin
        target  = $signed(DW'({sample, {FRAC_W{1'b0}}}));
        acc_ext = $signed(DW'(acc_old));
        delta   = target - acc_ext;
        mask    = $signed((DW'(1) << k) - DW'(1));
        unique case (mode)
            QM_ROUND:  bias = $signed(DW'(1) << (k - K_W'(1)));
            QM_DITHER: bias = $signed(DW'(dither)) & mask;
            default:   bias = '0;
        endcase
        sum_v = delta + bias;
        step  = sum_v >>> k;
        total = acc_ext + step;

        if (init) begin
            acc_new = target[ACC_W-1:0];
        end else if (total < 0) begin
            acc_new = '0;
        end else if (total > $signed(ACC_MAX)) begin
            acc_new = '1;
        end else begin
            acc_new = total[ACC_W-1:0];
        end

        rounded = DW'(acc_new) + HALF;
        if ((rounded >> FRAC_W) > OUT_MAX) begin
            avg_out = '1;
        end else begin
            avg_out = rounded[FRAC_W +: SAMPLE_W];
        end
    end

endmodule

// File: rtl/wave_avg_engine.sv
module wave_avg_engine
    import wave_avg_pkg::*;
#(
    parameter int           SAMPLE_W  = 8,
    parameter int           FRAC_W    = 8,
    parameter int           NPOINTS   = 1024,
    parameter int           K_MAX     = 8,
    parameter int           LFSR_W    = 16,
    parameter logic [15:0]  LFSR_SEED = 16'hACE1,
    parameter int           K_W       = $clog2(K_MAX + 1),
    parameter int           IDX_W     = $clog2(NPOINTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [K_W-1:0]      cfg_shift,
    input  logic [1:0]          cfg_mode,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_sweep_start,
    input  logic [IDX_W-1:0]    in_index,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_index,
    output logic [SAMPLE_W-1:0] out_avg
);

    localparam int ACC_W = SAMPLE_W + FRAC_W;

    avg_state_e            state;
    avg_state_e            state_nx;
    logic                  accept;
    logic [K_W-1:0]        k_eff;
    logic [K_W-1:0]        k_q;
    logic [K_W-1:0]        hold_k;
    qmode_e                hold_mode;
    logic [IDX_W-1:0]      hold_idx;
    logic [SAMPLE_W-1:0]   hold_sample;
    logic                  hold_init;
    logic                  init_active;
    logic                  seen_start;
    logic                  ram_en;
    logic                  ram_we;
    logic [IDX_W-1:0]      ram_addr;
    logic [ACC_W-1:0]      rd_acc;
    logic [ACC_W-1:0]      acc_new;
    logic [ACC_W-1:0]      hold_target;
    logic [SAMPLE_W-1:0]   avg_val;
    logic [LFSR_W-1:0]     lfsr_q;
    logic                  lfsr_step;

    // ---------------- effective shift, clamped to 1..K_MAX ----------------
    always_comb begin
        if (cfg_shift == '0) begin
            k_eff = K_W'(1);
        end else if (cfg_shift > K_W'(K_MAX)) begin
            k_eff = K_W'(K_MAX);
        end else begin
            k_eff = cfg_shift;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = in_index;
        lfsr_step = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                ram_en   = in_valid;
            end
            ST_WRITE: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = hold_idx;
                lfsr_step = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    // ---------------- capture of the accepted sample ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_idx    <= '0;
            hold_sample <= '0;
            hold_k      <= K_W'(1);
            hold_mode   <= QM_TRUNC;
            hold_init   <= 1'b1;
        end else if (accept) begin
            hold_idx    <= in_index;
            hold_sample <= in_sample;
            hold_k      <= k_eff;
            hold_mode   <= qmode_e'(cfg_mode);
            hold_init   <= init_active && !(in_sweep_start && seen_start);
        end
    end

    // ---------------- first-sweep load tracking ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q         <= K_W'(1);
            init_active <= 1'b1;
            seen_start  <= 1'b0;
        end else if (k_eff != k_q) begin
            k_q         <= k_eff;
            init_active <= 1'b1;
            seen_start  <= 1'b0;
        end else if (accept && in_sweep_start) begin
            if (seen_start) begin
                init_active <= 1'b0;
            end
            seen_start <= 1'b1;
        end
    end

    // ---------------- storage, dither source, arithmetic ----------------
    wave_avg_ram #(
        .WIDTH (ACC_W),
        .DEPTH (NPOINTS),
        .AW    (IDX_W)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (acc_new),
        .rdata (rd_acc)
    );

    wave_avg_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_W'(16'hB400)),
        .SEED (LFSR_W'(LFSR_SEED))
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (lfsr_step),
        .state   (lfsr_q)
    );

    wave_avg_update #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W),
        .K_W      (K_W),
        .ACC_W    (ACC_W)
    ) u_update (
        .acc_old (rd_acc),
        .sample  (hold_sample),
        .k       (hold_k),
        .mode    (hold_mode),
        .dither  (ACC_W'(lfsr_q)),
        .init    (hold_init),
        .acc_new (acc_new),
        .avg_out (avg_val)
    );

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_index <= '0;
            out_avg   <= '0;
        end else begin
            out_valid <= (state == ST_WRITE);
            if (state == ST_WRITE) begin
                out_index <= hold_idx;
                out_avg   <= avg_val;
            end
        end
    end

    assign hold_target = {hold_sample, {FRAC_W{1'b0}}};

    // R2: the write-back cycle blocks the port
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2: result appears two cycles after acceptance, tagged with its index
    a_r2_out_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 (out_valid && out_index == $past(in_index, 2)));

    // R9: an averaged step lands between the old value and the target
    a_r9_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !hold_init) |->
            ((rd_acc <= hold_target) ? (acc_new >= rd_acc && acc_new <= hold_target)
                                     : (acc_new <= rd_acc && acc_new >= hold_target)));

    // R2: nothing is emitted without a write-back in the preceding cycle
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(ram_we));

endmodule

// File: tb/tb_wave_avg_engine.sv
module tb_wave_avg_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 16;
    localparam int IW         = $clog2(NP);
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_shift = 4'd1;
    logic [1:0]    cfg_mode = 2'd0;
    logic          in_valid = 1'b0;
    logic          in_sweep_start = 1'b0;
    logic [IW-1:0] in_index = '0;
    logic [7:0]    in_sample = '0;
    logic          in_ready;
    logic          out_valid;
    logic [IW-1:0] out_index;
    logic [7:0]    out_avg;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wave_avg_engine #(.NPOINTS(NP)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_shift      (cfg_shift),
        .cfg_mode       (cfg_mode),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_sweep_start (in_sweep_start),
        .in_index       (in_index),
        .in_sample      (in_sample),
        .out_valid      (out_valid),
        .out_index      (out_index),
        .out_avg        (out_avg)
    );

    typedef struct {
        int    idx;
        int    val;
        string tag;
    } exp_t;

    exp_t        expq[$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          m_acc[NP];
    int          last_out[NP];
    int          last_sent[NP];
    bit          m_init;
    bit          m_seen;
    logic [15:0] m_lfsr;
    int          m_k;
    int          m_mode;
    int          seed = 12345;
    string       cur_tag = "R4";

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference: behavioural per-point recursion
    task automatic model_accept(int idx, bit ss, int s);
        bit ld;
        int delta;
        int bias;
        int acc;
        int o;
        ld = m_init && !(ss && m_seen);
        if (ss) begin
            if (m_init && m_seen) m_init = 1'b0;
            m_seen = 1'b1;
        end
        if (ld) begin
            acc = s * 256;
        end else begin
            delta = s * 256 - m_acc[idx];
            case (m_mode)
                1:       bias = 1 << (m_k - 1);
                2:       bias = int'(m_lfsr) & ((1 << m_k) - 1);
                default: bias = 0;
            endcase
            acc = m_acc[idx] + ((delta + bias) >>> m_k);
            if (acc < 0) acc = 0;
            if (acc > 65535) acc = 65535;
        end
        m_acc[idx] = acc;
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        o = (acc + 128) >> 8;
        if (o > 255) o = 255;
        expq.push_back('{idx, o, cur_tag});
    endtask

    // output monitor, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected output", int'(out_avg), -1);
            end else begin
                e = expq.pop_front();
                check(int'(out_index) == e.idx, {e.tag, " index"}, int'(out_index), e.idx);
                check(int'(out_avg) == e.val, {e.tag, " value"}, int'(out_avg), e.val);
            end
            last_out[out_index] = int'(out_avg);
        end
    end

    task automatic send(int idx, bit ss, int s);
        while (!in_ready) @(negedge clk);
        in_valid       = 1'b1;
        in_index       = IW'(idx);
        in_sweep_start = ss;
        in_sample      = 8'(s);
        @(posedge clk);
        model_accept(idx, ss, s);
        @(negedge clk);
        in_valid       = 1'b0;
        in_sweep_start = 1'b0;
        check(!in_ready, "R2 ready low after accept", int'(in_ready), 0);
        @(negedge clk);
        check(out_valid && int'(out_index) == idx, "R2 output latency", int'(out_index), idx);
    endtask

    task automatic set_cfg(int kraw, int mode);
        int keff;
        cfg_shift = 4'(kraw);
        cfg_mode  = 2'(mode);
        keff = (kraw == 0) ? 1 : ((kraw > 8) ? 8 : kraw);
        if (keff != m_k) begin
            m_init = 1'b1;
            m_seen = 1'b0;
            m_k    = keff;
        end
        m_mode = (mode == 3) ? 0 : mode;
        repeat (2) @(negedge clk);
    endtask

    task automatic sweep(int base, int amp, int stride);
        for (int j = 0; j < NP; j++) begin
            int i;
            int s;
            i = (j * stride) % NP;
            seed = seed * 1103515245 + 12345;
            s = base + i * 9;
            if (amp > 0) s = s + ((seed >>> 16) & 32'h7fff) % (2 * amp + 1) - amp;
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            last_sent[i] = s;
            send(i, j == 0, s);
        end
    endtask

    task automatic check_loaded(string tag);
        repeat (2) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            check(last_out[i] == last_sent[i], tag, last_out[i], last_sent[i]);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_init = 1'b1;
        m_seen = 1'b0;
        m_k    = 1;
        m_mode = 0;
        m_lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 no output in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 idle output after reset", int'(out_valid), 0);

        // R3: first sweep loads, R4: then recursive truncating averages
        set_cfg(2, 0);
        cur_tag = "R3";
        sweep(60, 0, 1);
        check_loaded("R3 first sweep loads sample");
        cur_tag = "R4";
        for (int n = 0; n < 5; n++) sweep(60, 20, 1);

        // R10: strided point order
        cur_tag = "R10";
        for (int n = 0; n < 4; n++) sweep(60, 20, 5);

        // R8: shift 0 acts as 1 (and reloads), 12 acts as 8
        set_cfg(0, 1);
        cur_tag = "R8";
        sweep(40, 10, 1);
        check_loaded("R3 reload after k change");
        for (int n = 0; n < 4; n++) sweep(40, 30, 3);
        set_cfg(12, 1);
        sweep(90, 0, 1);
        check_loaded("R3 reload after clamped k change");
        for (int n = 0; n < 4; n++) sweep(90, 30, 1);

        // R7: dither at k = 8 (no reload: k unchanged)
        set_cfg(12, 2);
        cur_tag = "R7";
        for (int n = 0; n < 6; n++) sweep(90, 25, 7);

        // R5: truncation dead band at k = 8
        set_cfg(7, 0);
        set_cfg(8, 0);
        cur_tag = "R5";
        send(0, 1'b1, 100);
        for (int n = 0; n < 150; n++) send(0, 1'b1, 101);
        repeat (2) @(negedge clk);
        check(last_out[0] == 100, "R5 truncate stuck in dead band", last_out[0], 100);

        // R6: rounding leaves the band (same k, no reload)
        set_cfg(8, 1);
        cur_tag = "R6";
        for (int n = 0; n < 150; n++) send(0, 1'b1, 101);
        repeat (2) @(negedge clk);
        check(last_out[0] == 101, "R6 round escapes dead band", last_out[0], 101);

        // R7: dither also escapes the band
        set_cfg(7, 2);
        set_cfg(8, 2);
        cur_tag = "R7";
        send(0, 1'b1, 100);
        for (int n = 0; n < 400; n++) send(0, 1'b1, 101);
        repeat (2) @(negedge clk);
        check(last_out[0] == 101, "R7 dither escapes dead band", last_out[0], 101);

        // R9: full-scale and zero-scale extremes
        set_cfg(1, 1);
        cur_tag = "R9";
        send(3, 1'b1, 255);
        for (int n = 0; n < 10; n++) send(3, 1'b1, 255);
        repeat (2) @(negedge clk);
        check(last_out[3] == 255, "R9 full scale output", last_out[3], 255);
        for (int n = 0; n < 20; n++) send(3, 1'b1, 0);
        repeat (2) @(negedge clk);
        check(last_out[3] == 0, "R9 zero scale output", last_out[3], 0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule